// File: doc/BRIEF.md
# RC6 Round-Key Expansion Unit

This block turns a user key of 8, 16 or 32 bytes into the 44 round-key words of 32 bits each that a 20-round RC6 datapath consumes. The host writes the key one 32-bit word at a time into a small key store and pulses `start`. The unit then fills the round-key array with the arithmetic seed sequence and runs the mixing pass that folds the key into it. Both the encrypt and decrypt datapaths read the finished array through one asynchronous read port, so the host never has to load round keys itself.

Setup always takes the same number of cycles, whatever the key length. Writing a key word or starting a new setup drops `ready`. The cipher must wait until `ready` is high again. The mixing pass overwrites the key store, so the host must write the key again before it runs a second setup.

Top module: `rc6_keysched`

## Requirements
- R1: After reset, `ready` is low and every round-key word reads as zero.
- R2: `key_len` is sampled together with an accepted `start`. Code 0 selects 2 key words (64 bits), code 1 selects 4 words (128 bits), and codes 2 and 3 select 8 words (256 bits). Key word k holds user bytes 4k to 4k+3, with the lowest-addressed byte in bits 7:0.
- R3: When setup ends, word n of the array equals the standard RC6 expansion result. The array is seeded with 0xB7E15163 plus n times 0x9E3779B9. Then 132 mixing steps run, where A = rotl(S[i]+A+B, 3) and B = rotl(L[j]+A+B, (A+B) mod 32), with i wrapping at 44 and j wrapping at the number of key words.
- R4: `ready` rises on the 188th rising clock edge after the edge that accepts `start`, for every key length, and it is never high while setup runs.
- R5: An accepted `start`, or a key write while idle, makes `ready` low from the next edge on.
- R6: While setup runs, `start` and key writes are ignored. Neither the finish time nor the final array changes.
- R7: A key write in the same cycle as an accepted `start` is used by that setup.
- R8: A read address of 44 or above returns zero.
- R9: `rd_data` follows `rd_addr` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_we | input | 1 | Key word write strobe |
| key_widx | input | 3 | Key word index |
| key_wdata | input | 32 | Key word value, little-endian bytes |
| key_len | input | 2 | Key length code, sampled with start |
| start | input | 1 | Begin expansion pulse |
| rd_addr | input | 6 | Round-key read index |
| rd_data | output | 32 | Round-key word at rd_addr |
| ready | output | 1 | Round-key array valid |

## Verification
A key write and the start of an expansion can land on the same clock edge. The bench provokes this by writing the last of eight key words in the very cycle that `start` is pulsed. It then judges the outcome by comparing the whole array against a model that includes that word. A second collision is provoked by writing a foreign key word and pulsing `start` again partway through a setup. Here the bench expects the finish edge to stay unchanged and the array to still match the original key.

// File: rtl/rc6ks_pkg.sv
package rc6ks_pkg;
   localparam int WORD_W = 32;
   localparam logic [WORD_W-1:0] SEED_P = 32'hB7E15163;
   localparam logic [WORD_W-1:0] STEP_Q = 32'h9E3779B9;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [1:0] {
      KLEN_64  = 2'd0,
      KLEN_128 = 2'd1,
      KLEN_256 = 2'd2,
      KLEN_ALT = 2'd3
   } klen_e;

   function automatic word_t rotl(input word_t x, input logic [4:0] n);
      logic [2*WORD_W-1:0] dbl;
      dbl = {x, x} << n;
      return dbl[2*WORD_W-1:WORD_W];
   endfunction
endpackage

// File: rtl/rc6ks_regfile.sv
module rc6ks_regfile #(
   parameter int DEPTH     = 44,
   parameter int WIDTH     = 32,
   parameter int NRD       = 1,
   parameter bit RST_CLEAR = 1'b1,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [AW-1:0]             waddr,
   input  logic [WIDTH-1:0]          wdata,
   input  logic [NRD-1:0][AW-1:0]    raddr,
   output logic [NRD-1:0][WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      logic [WIDTH-1:0] cell_q;
      if (RST_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             cell_q <= '0;
            else if (we && waddr == AW'(e))         cell_q <= wdata;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we && waddr == AW'(e))              cell_q <= wdata;
         end
      end
      assign mem[e] = cell_q;
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rdata[r] = ({1'b0, raddr[r]} < (AW+1)'(DEPTH)) ? mem[raddr[r]] : '0;
   end

   // R3
   waddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> ({1'b0, waddr} < (AW+1)'(DEPTH)));
endmodule

// File: rtl/rc6ks_ctrl.sv
module rc6ks_ctrl
   import rc6ks_pkg::*;
#(
   parameter int NW     = 44,
   parameter int MAXKW  = 8,
   parameter int SETUP  = 188,
   localparam int SAW   = $clog2(NW),
   localparam int LAW   = $clog2(MAXKW),
   localparam int CW    = $clog2(SETUP),
   localparam int MIXN  = 3 * ((NW > MAXKW) ? NW : MAXKW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           key_we,
   input  logic [1:0]     key_len,
   output logic           busy,
   output logic           ready,
   output logic           init_act,
   output logic           mix_act,
   output logic [SAW-1:0] s_idx,
   output logic [LAW-1:0] l_idx
);
   logic [CW-1:0] cnt;
   logic [LAW:0]  kw_q;
   logic [LAW:0]  kw_dec;
   logic          accept;

   assign accept = start && !busy;

   always_comb begin
      case (klen_e'(key_len))
         KLEN_64:  kw_dec = (LAW+1)'(2);
         KLEN_128: kw_dec = (LAW+1)'(4);
         default:  kw_dec = (LAW+1)'(MAXKW);
      endcase
   end

   assign init_act = busy && (cnt < CW'(NW));
   assign mix_act  = busy && (cnt >= CW'(NW)) && (cnt < CW'(NW + MIXN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         ready <= 1'b0;
         cnt   <= '0;
         kw_q  <= (LAW+1)'(MAXKW);
         s_idx <= '0;
         l_idx <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         ready <= 1'b0;
         cnt   <= '0;
         kw_q  <= kw_dec;
         s_idx <= '0;
         l_idx <= '0;
      end else if (busy) begin
         cnt <= cnt + 1'b1;
         if (init_act || mix_act)
            s_idx <= (s_idx == SAW'(NW - 1)) ? '0 : s_idx + 1'b1;
         if (mix_act)
            l_idx <= ({1'b0, l_idx} == kw_q - 1'b1) ? '0 : l_idx + 1'b1;
         if (cnt == CW'(SETUP - 1)) begin
            busy  <= 1'b0;
            ready <= 1'b1;
         end
      end else if (key_we) begin
         ready <= 1'b0;
      end
   end

   // R4
   done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (ready && $past(cnt) == CW'(SETUP - 1)));
   // R4
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && ready));
   // R5
   load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_we && !busy && !start) |=> !ready);
   // R6
   restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cnt != CW'(SETUP - 1)) |=> (busy && cnt == CW'($past(cnt) + 1'b1)));
   // R3
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({1'b0, s_idx} < (SAW+1)'(NW) && {1'b0, l_idx} < kw_q));
endmodule

// File: rtl/rc6ks_mix.sv
module rc6ks_mix
   import rc6ks_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clear,
   input  logic  init_act,
   input  logic  mix_act,
   input  word_t s_rd,
   input  word_t l_rd,
   output word_t s_wdata,
   output word_t l_wdata
);
   word_t a_q, b_q, seed_q;
   word_t a_nx, ab_sum, b_nx;

   always_comb begin
      a_nx   = rotl(s_rd + a_q + b_q, 5'd3);
      ab_sum = a_nx + b_q;
      b_nx   = rotl(l_rd + ab_sum, ab_sum[4:0]);
   end

   assign s_wdata = init_act ? seed_q : a_nx;
   assign l_wdata = b_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         seed_q <= SEED_P;
      end else if (clear) begin
         a_q    <= '0;
         b_q    <= '0;
         seed_q <= SEED_P;
      end else if (init_act) begin
         seed_q <= seed_q + STEP_Q;
      end else if (mix_act) begin
         a_q <= a_nx;
         b_q <= b_nx;
      end
   end

   // R3
   seed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init_act && $past(init_act)) |-> (s_wdata == $past(s_wdata) + STEP_Q));
endmodule

// File: rtl/rc6_keysched.sv
module rc6_keysched
   import rc6ks_pkg::*;
#(
   parameter int ROUNDS = 20,
   parameter int MAXKW  = 8,
   parameter int SETUP  = 188,
   localparam int NW    = 2 * ROUNDS + 4,
   localparam int SAW   = $clog2(NW),
   localparam int LAW   = $clog2(MAXKW),
   localparam int MIXN  = 3 * ((NW > MAXKW) ? NW : MAXKW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_we,
   input  logic [LAW-1:0]    key_widx,
   input  logic [WORD_W-1:0] key_wdata,
   input  logic [1:0]        key_len,
   input  logic              start,
   input  logic [SAW-1:0]    rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              ready
);
   if (ROUNDS < 1) begin : g_bad_rounds
      $error("ROUNDS must be at least 1");
   end
   if (MAXKW != 8) begin : g_bad_keywords
      $error("MAXKW must be 8");
   end
   if (SETUP < NW + MIXN) begin : g_bad_setup
      $error("SETUP too short for seeding plus mixing");
   end

   logic           busy, init_act, mix_act;
   logic [SAW-1:0] s_idx;
   logic [LAW-1:0] l_idx;
   word_t          s_wdata, l_mix, l_wdata;
   logic           l_we;
   logic [LAW-1:0] l_waddr;
   logic [1:0][SAW-1:0] s_raddr;
   logic [1:0][WORD_W-1:0] s_rdata;
   logic [0:0][LAW-1:0] l_raddr;
   logic [0:0][WORD_W-1:0] l_rdata;

   rc6ks_ctrl #(.NW(NW), .MAXKW(MAXKW), .SETUP(SETUP)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .key_we(key_we), .key_len(key_len),
      .busy(busy), .ready(ready), .init_act(init_act), .mix_act(mix_act),
      .s_idx(s_idx), .l_idx(l_idx)
   );

   rc6ks_mix u_mix (
      .clk(clk), .rst_n(rst_n), .clear(start && !busy),
      .init_act(init_act), .mix_act(mix_act),
      .s_rd(s_rdata[0]), .l_rd(l_rdata[0]),
      .s_wdata(s_wdata), .l_wdata(l_mix)
   );

   assign s_raddr[0] = s_idx;
   assign s_raddr[1] = rd_addr;
   assign rd_data    = s_rdata[1];

   rc6ks_regfile #(.DEPTH(NW), .WIDTH(WORD_W), .NRD(2), .RST_CLEAR(1'b1)) u_sarr (
      .clk(clk), .rst_n(rst_n), .we(init_act || mix_act), .waddr(s_idx),
      .wdata(s_wdata), .raddr(s_raddr), .rdata(s_rdata)
   );

   assign l_we       = mix_act || (key_we && !busy);
   assign l_waddr    = mix_act ? l_idx : key_widx;
   assign l_wdata    = mix_act ? l_mix : key_wdata;
   assign l_raddr[0] = l_idx;

   rc6ks_regfile #(.DEPTH(MAXKW), .WIDTH(WORD_W), .NRD(1), .RST_CLEAR(1'b0)) u_larr (
      .clk(clk), .rst_n(rst_n), .we(l_we), .waddr(l_waddr),
      .wdata(l_wdata), .raddr(l_raddr), .rdata(l_rdata)
   );

   // R5
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !ready));
endmodule

// File: tb/rc6_keysched_bench.sv
`timescale 1ns/1ps
module rc6_keysched_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_we = 1'b0;
   logic [2:0]  key_widx = '0;
   logic [31:0] key_wdata = '0;
   logic [1:0]  key_len = '0;
   logic        start = 1'b0;
   logic [5:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        ready;

   always #4 clk = ~clk;

   rc6_keysched u_rc6_keysched (
      .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_widx(key_widx),
      .key_wdata(key_wdata), .key_len(key_len), .start(start),
      .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
   );

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] kbuf [8];
   logic [31:0] ref_s [44];
   logic [5:0]  qa [$];
   logic [31:0] qd [$];
   string       qt [$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      int m;
      m = n % 32;
      return (x << m) | (x >> (32 - m));
   endfunction

   task automatic ref_expand(input int c);
      logic [31:0] lw [8];
      logic [31:0] a, b;
      int i, j;
      for (int k = 0; k < 8; k++) lw[k] = kbuf[k];
      ref_s[0] = 32'hB7E15163;
      for (int k = 1; k < 44; k++) ref_s[k] = ref_s[k-1] + 32'h9E3779B9;
      a = 0; b = 0; i = 0; j = 0;
      for (int n = 0; n < 132; n++) begin
         a = rl(ref_s[i] + a + b, 3);
         ref_s[i] = a;
         b = rl(lw[j] + a + b, int'((a + b) & 32'h1f));
         lw[j] = b;
         i = (i + 1) % 44;
         j = (j + 1) % c;
      end
   endtask

   task automatic push(input logic [5:0] a, input logic [31:0] d, input string tag);
      qa.push_back(a);
      qd.push_back(d);
      qt.push_back(tag);
   endtask

   task automatic push_all(input string tag);
      for (int k = 0; k < 44; k++) push(6'(k), ref_s[k], tag);
   endtask

   task automatic drain;
      wait (qa.size() == 0);
      @(negedge clk);
   endtask

   // Monitor: reads combinationally within the cycle the address is set (R9)
   initial begin
      forever begin
         @(negedge clk);
         if (qa.size() > 0) begin
            logic [31:0] exp;
            string tag;
            rd_addr = qa.pop_front();
            exp = qd.pop_front();
            tag = qt.pop_front();
            #2;
            chk(rd_data === exp, tag, rd_data, exp);
         end
      end
   end

   task automatic load_key(input int nw, input logic [31:0] seed);
      for (int k = 0; k < nw; k++) begin
         @(negedge clk);
         key_we = 1'b1;
         key_widx = 3'(k);
         key_wdata = seed ^ (32'h01020304 * (k + 1)) ^ {24'h0, 8'(k)};
         kbuf[k] = key_wdata;
      end
      @(negedge clk);
      key_we = 1'b0;
   endtask

   task automatic kick(input logic [1:0] len);
      @(negedge clk);
      start = 1'b1;
      key_len = len;
      @(negedge clk);
      start = 1'b0;
      chk(ready == 1'b0, "R5 start clears ready", 32'(ready), 32'h0);
   endtask

   task automatic finish_time(input int pre, input string tag);
      repeat (pre) @(negedge clk);
      chk(ready == 1'b0, tag, 32'(ready), 32'h0);
      @(negedge clk);
      chk(ready == 1'b1, tag, 32'(ready), 32'h1);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      summary();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(ready == 1'b0, "R1 ready after reset", 32'(ready), 32'h0);
      push(6'd0, 32'h0, "R1 word 0 after reset");
      push(6'd43, 32'h0, "R1 word 43 after reset");
      drain();

      // R2 R3 R4: 128-bit key
      load_key(4, 32'h0F1E2D3C);
      kick(2'd1);
      finish_time(187, "R4 finish 128-bit");
      ref_expand(4);
      push_all("R3 128-bit array");
      push(6'd44, 32'h0, "R8 address 44");
      push(6'd63, 32'h0, "R8 address 63");
      drain();

      // R5: key write while idle drops ready
      @(negedge clk);
      key_we = 1'b1; key_widx = 3'd0; key_wdata = 32'h12345678;
      @(negedge clk);
      key_we = 1'b0;
      chk(ready == 1'b0, "R5 key write clears ready", 32'(ready), 32'h0);

      // R6: 64-bit key, foreign write and restart mid-setup
      load_key(2, 32'hA5A55A5A);
      kick(2'd0);
      repeat (60) @(negedge clk);
      key_we = 1'b1; key_widx = 3'd1; key_wdata = 32'hDEADBEEF; start = 1'b1; key_len = 2'd2;
      @(negedge clk);
      key_we = 1'b0; start = 1'b0;
      finish_time(126, "R6 finish unchanged by restart");
      ref_expand(2);
      push_all("R6 R2 64-bit array unaffected");
      drain();

      // R7: last key word written in the same cycle as start
      load_key(7, 32'h31415926);
      @(negedge clk);
      key_we = 1'b1; key_widx = 3'd7; key_wdata = 32'hCAFEF00D; kbuf[7] = 32'hCAFEF00D;
      start = 1'b1; key_len = 2'd2;
      @(negedge clk);
      key_we = 1'b0; start = 1'b0;
      chk(ready == 1'b0, "R5 start with write clears ready", 32'(ready), 32'h0);
      finish_time(187, "R4 finish 256-bit");
      ref_expand(8);
      push_all("R7 256-bit array with same-cycle word");
      drain();

      // R2: code 3 behaves as 256-bit
      load_key(8, 32'h27182818);
      kick(2'd3);
      finish_time(187, "R4 finish code 3");
      ref_expand(8);
      push_all("R2 code 3 as 256-bit");
      drain();

      summary();
   end
endmodule